// File: doc/BRIEF.md
# LIN Identifier Acceptance Filter Bank

This block decides whether a received 6-bit LIN frame identifier needs attention. It compares the identifier against a bank of eight filters. When a filter hits, it returns the settings stored for that filter: the filter index, the frame direction, the data field length and the checksum type. Only identifiers that the filter policy accepts raise a receive event, so the controller upstream does not have to sort identifiers itself.

The filters are grouped in pairs (0,1), (2,3), (4,5) and (6,7), with one mode bit per pair. With the mode bit clear, both filters of the pair compare the identifier exactly. With the mode bit set, the odd filter's identifier field becomes a bit mask for the even filter, and the odd filter no longer matches anything by itself.

The block has no bus protocol. A one-cycle write strobe selects one of three targets: a filter configuration register, the enable register or the mode register. The identifier arrives with a one-cycle valid strobe, and the result is a registered one-cycle pulse.

Top module: `lin_id_filter_bank`

## Requirements
- R1: After reset all enable bits, all mode bits and every configuration field are zero, and every output is low. Consequently, enabling filter 0 alone makes only identifier 0 hit, with length 0, direction 0 and checksum type 0.
- R2: Write port. `wr_sel`=0 writes filter `wr_idx` with `wr_data[5:0]`=identifier, `[8:6]`=data length, `[9]`=direction (1 transmit, 0 receive) and `[10]`=checksum type. `wr_sel`=1 loads `wr_data[7:0]` into the enable bits, one bit per filter. `wr_sel`=2 loads `wr_data[3:0]` into the pair mode bits; bit p controls filters 2p and 2p+1. `wr_sel`=3 does nothing.
- R3: In list mode (mode bit 0), each enabled filter of the pair hits only when all six identifier bits equal its identifier field. The two filters of the pair work independently.
- R4: In mask mode (mode bit 1), the even filter hits when the identifier equals its identifier field on every bit where the odd filter's identifier field holds a 1; bits where the mask is 0 are don't-care. The pair is active when the even enable bit is set. The odd filter never hits, and its enable bit is ignored.
- R5: On a hit, `hit_dir`, `hit_dfl` and `hit_csum` carry the winning filter's fields; in mask mode these are the even filter's fields.
- R6: When several active filters hit, the lowest filter index wins and appears on `hit_idx`.
- R7: `hit` and the result outputs are valid for exactly one cycle, one clock after `id_valid`. When there is no hit, all result fields are zero.
- R8: When no filter is active, every received identifier produces an `rx_irq` pulse with `hit` low.
- R9: When at least one filter is active and none hits, neither `hit` nor `rx_irq` is raised.
- R10: On a hit, `rx_irq` pulses together with `hit` only when the winning filter's direction is receive (0).
- R11: A configuration write to a locked filter is ignored, and `wr_err` pulses one cycle after the write. A filter is locked while its own enable bit is set. An odd filter is also locked while its pair is in mask mode and the even enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 filter config, 1 enables, 2 modes |
| wr_idx | input | 3 | Filter index for a config write |
| wr_data | input | 11 | Write data |
| id_valid | input | 1 | Identifier valid strobe |
| id_in | input | 6 | Received identifier |
| hit | output | 1 | One-cycle match pulse |
| hit_idx | output | 3 | Index of the winning filter |
| hit_dir | output | 1 | Winning filter direction (1 transmit) |
| hit_dfl | output | 3 | Winning filter data length |
| hit_csum | output | 1 | Winning filter checksum type |
| rx_irq | output | 1 | Receive event pulse |
| wr_err | output | 1 | Rejected configuration write pulse |

## Verification
The hardest state to reach is an odd filter in a mask-mode pair. Its own enable bit says nothing about whether it matches or whether it may be written; both depend on its partner's enable bit and on the pair mode. The bench reaches this state by loading masks while every enable is clear, then enabling only the even partner or only the odd filter. At each step it attempts writes and sweeps all 64 identifiers. Overlapping identifiers in list mode and mask mode exercise the priority rule and the effect of the mask on the result fields.

// File: rtl/lin_filt_pkg.sv
package lin_filt_pkg;
  localparam int LIN_ID_W  = 6;
  localparam int LIN_DFL_W = 3;
  localparam int CFG_W     = LIN_ID_W + LIN_DFL_W + 2;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_EN   = 2'd1,
    SEL_MODE = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  typedef struct packed {
    logic                 csum;
    logic                 dir;
    logic [LIN_DFL_W-1:0] dfl;
    logic [LIN_ID_W-1:0]  id;
  } filt_cfg_t;

  // identifier equal on every bit that the care mask selects
  function automatic logic id_agrees(input logic [LIN_ID_W-1:0] rx_id,
                                     input logic [LIN_ID_W-1:0] ref_id,
                                     input logic [LIN_ID_W-1:0] care);
    return ((rx_id ^ ref_id) & care) == '0;
  endfunction
endpackage

// File: rtl/lin_filt_regs.sv
module lin_filt_regs
  import lin_filt_pkg::*;
#(
  parameter int NF    = 8,
  parameter int IDX_W = $clog2(NF),
  parameter int NP    = NF / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [CFG_W-1:0]     wr_data,
  output filt_cfg_t [NF-1:0]   cfg_q,
  output logic [NF-1:0]        en_q,
  output logic [NP-1:0]        mode_q,
  output logic                 wr_err
);
  logic [NF-1:0] lock;
  logic [NF-1:0] cfg_req;
  logic          cfg_sel;

  assign cfg_sel = wr_en && (wr_sel == SEL_CFG);

  for (genvar i = 0; i < NF; i++) begin : g_lock
    if (i % 2 == 1) begin : g_odd
      assign lock[i] = en_q[i] | (mode_q[i/2] & en_q[i-1]);
    end else begin : g_even
      assign lock[i] = en_q[i];
    end
    assign cfg_req[i] = cfg_sel && (wr_idx == IDX_W'(i));

    // R11: a locked filter keeps its configuration
    assert_locked_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req[i] && lock[i]) |=> $stable(cfg_q[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      en_q   <= '0;
      mode_q <= '0;
      wr_err <= 1'b0;
    end else begin
      wr_err <= cfg_sel && lock[wr_idx];
      for (int i = 0; i < NF; i++) begin
        if (cfg_req[i] && !lock[i]) cfg_q[i] <= filt_cfg_t'(wr_data);
      end
      if (wr_en && wr_sel == SEL_EN)   en_q   <= wr_data[NF-1:0];
      if (wr_en && wr_sel == SEL_MODE) mode_q <= wr_data[NP-1:0];
    end
  end

  assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(cfg_sel));
endmodule

// File: rtl/lin_filt_match.sv
module lin_filt_match
  import lin_filt_pkg::*;
#(
  parameter int NF = 8,
  parameter int NP = NF / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LIN_ID_W-1:0] id_in,
  input  filt_cfg_t [NF-1:0]  cfg_q,
  input  logic [NF-1:0]       en_q,
  input  logic [NP-1:0]       mode_q,
  output logic [NF-1:0]       match_vec,
  output logic [NF-1:0]       act_vec
);
  for (genvar p = 0; p < NP; p++) begin : g_pair
    logic [LIN_ID_W-1:0] care_even;
    assign care_even = mode_q[p] ? cfg_q[2*p+1].id : {LIN_ID_W{1'b1}};

    assign act_vec[2*p]   = en_q[2*p];
    assign act_vec[2*p+1] = en_q[2*p+1] & ~mode_q[p];

    assign match_vec[2*p]   = act_vec[2*p] &
                              id_agrees(id_in, cfg_q[2*p].id, care_even);
    assign match_vec[2*p+1] = act_vec[2*p+1] &
                              id_agrees(id_in, cfg_q[2*p+1].id, {LIN_ID_W{1'b1}});

    // R4: the mask half of a pair never hits by itself
    assert_mask_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[p] |-> !match_vec[2*p+1]);
  end
endmodule

// File: rtl/lin_filt_result.sv
module lin_filt_result
  import lin_filt_pkg::*;
#(
  parameter int NF    = 8,
  parameter int IDX_W = $clog2(NF)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 id_valid,
  input  logic [NF-1:0]        match_vec,
  input  logic [NF-1:0]        act_vec,
  input  filt_cfg_t [NF-1:0]   cfg_q,
  output logic                 hit,
  output logic [IDX_W-1:0]     hit_idx,
  output logic                 hit_dir,
  output logic [LIN_DFL_W-1:0] hit_dfl,
  output logic                 hit_csum,
  output logic                 rx_irq
);
  logic             none_active;
  logic             any_match;
  logic [IDX_W-1:0] win_idx;
  filt_cfg_t        win_cfg;
  logic             irq_next;

  assign none_active = (act_vec == '0);
  assign any_match   = |match_vec;

  always_comb begin
    win_idx = '0;
    for (int i = NF - 1; i >= 0; i--) begin
      if (match_vec[i]) win_idx = IDX_W'(i);
    end
  end

  assign win_cfg  = cfg_q[win_idx];
  assign irq_next = id_valid && (none_active || (any_match && !win_cfg.dir));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit      <= 1'b0;
      hit_idx  <= '0;
      hit_dir  <= 1'b0;
      hit_dfl  <= '0;
      hit_csum <= 1'b0;
      rx_irq   <= 1'b0;
    end else begin
      hit      <= id_valid && any_match;
      rx_irq   <= irq_next;
      if (id_valid && any_match) begin
        hit_idx  <= win_idx;
        hit_dir  <= win_cfg.dir;
        hit_dfl  <= win_cfg.dfl;
        hit_csum <= win_cfg.csum;
      end else begin
        hit_idx  <= '0;
        hit_dir  <= 1'b0;
        hit_dfl  <= '0;
        hit_csum <= 1'b0;
      end
    end
  end

  assert_hit_follows_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(id_valid));
  assert_idle_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && none_active) |=> (rx_irq && !hit));
  assert_miss_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !none_active && !any_match) |=> (!rx_irq && !hit));
  assert_tx_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && hit_dir) |-> !rx_irq);
  assert_win_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && any_match) |-> match_vec[win_idx] &&
      ((match_vec & ((NF'(1) << win_idx) - NF'(1))) == '0));
endmodule

// File: rtl/lin_id_filter_bank.sv
module lin_id_filter_bank
  import lin_filt_pkg::*;
#(
  parameter int NF    = 8,
  parameter int IDX_W = $clog2(NF),
  parameter int NP    = NF / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [CFG_W-1:0]     wr_data,
  input  logic                 id_valid,
  input  logic [LIN_ID_W-1:0]  id_in,
  output logic                 hit,
  output logic [IDX_W-1:0]     hit_idx,
  output logic                 hit_dir,
  output logic [LIN_DFL_W-1:0] hit_dfl,
  output logic                 hit_csum,
  output logic                 rx_irq,
  output logic                 wr_err
);
  filt_cfg_t [NF-1:0] cfg_q;
  logic [NF-1:0]      en_q;
  logic [NP-1:0]      mode_q;
  logic [NF-1:0]      match_vec;
  logic [NF-1:0]      act_vec;

  lin_filt_regs #(.NF(NF), .IDX_W(IDX_W), .NP(NP)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_idx(wr_idx), .wr_data(wr_data), .cfg_q(cfg_q), .en_q(en_q),
    .mode_q(mode_q), .wr_err(wr_err)
  );

  lin_filt_match #(.NF(NF), .NP(NP)) u_match (
    .clk(clk), .rst_n(rst_n), .id_in(id_in), .cfg_q(cfg_q), .en_q(en_q),
    .mode_q(mode_q), .match_vec(match_vec), .act_vec(act_vec)
  );

  lin_filt_result #(.NF(NF), .IDX_W(IDX_W)) u_result (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .match_vec(match_vec),
    .act_vec(act_vec), .cfg_q(cfg_q), .hit(hit), .hit_idx(hit_idx),
    .hit_dir(hit_dir), .hit_dfl(hit_dfl), .hit_csum(hit_csum), .rx_irq(rx_irq)
  );
endmodule

// File: tb/tb_lin_id_filter_bank.sv
module tb_lin_id_filter_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [2:0]  wr_idx = 3'd0;
  logic [10:0] wr_data = '0;
  logic        id_valid = 1'b0;
  logic [5:0]  id_in = '0;
  logic        hit, hit_dir, hit_csum, rx_irq, wr_err;
  logic [2:0]  hit_idx, hit_dfl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [10:0] m_cfg [8];
  logic [7:0]  m_en;
  logic [3:0]  m_mode;

  always #5ns clk = ~clk;

  lin_id_filter_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .id_valid(id_valid), .id_in(id_in), .hit(hit),
    .hit_idx(hit_idx), .hit_dir(hit_dir), .hit_dfl(hit_dfl),
    .hit_csum(hit_csum), .rx_irq(rx_irq), .wr_err(wr_err)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic filt_live(input int f);
    if (f % 2 == 1) return m_en[f] && !m_mode[f/2];
    return m_en[f];
  endfunction

  // expected {hit, idx, dir, dfl, csum, irq}
  function automatic logic [9:0] predict(input logic [5:0] id);
    bit any_live = 0;
    for (int f = 0; f < 8; f++) if (filt_live(f)) any_live = 1;
    if (!any_live) return 10'b1;
    for (int f = 0; f < 8; f++) begin
      if (filt_live(f)) begin
        logic [5:0] care;
        care = (f % 2 == 0 && m_mode[f/2]) ? m_cfg[f+1][5:0] : 6'h3f;
        if (((id ^ m_cfg[f][5:0]) & care) == 6'h00)
          return {1'b1, 3'(f), m_cfg[f][9], m_cfg[f][8:6], m_cfg[f][10], ~m_cfg[f][9]};
      end
    end
    return 10'b0;
  endfunction

  task automatic wr(input logic [1:0] sel, input int idx, input logic [10:0] data);
    logic locked;
    locked = m_en[idx] || (idx % 2 == 1 && m_mode[idx/2] && m_en[idx-1]);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_idx = 3'(idx); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel == 2'd0) begin
      check("R11 wr_err", 16'(wr_err), 16'(locked));
      if (!locked) m_cfg[idx] = data;
    end
    if (sel == 2'd1) m_en = data[7:0];
    if (sel == 2'd2) m_mode = data[3:0];
  endtask

  task automatic probe(input logic [5:0] id, input string req);
    logic [9:0] exp;
    exp = predict(id);
    @(negedge clk);
    id_valid = 1'b1; id_in = id;
    @(negedge clk);
    id_valid = 1'b0;
    check(req, 16'({hit, hit_idx, hit_dir, hit_dfl, hit_csum, rx_irq}), 16'(exp));
    @(negedge clk);
    check("R7 single pulse", 16'({hit, rx_irq}), 16'd0);
  endtask

  task automatic sweep(input string req);
    for (int id = 0; id < 64; id++) probe(6'(id), req);
  endtask

  initial begin
    #100us;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < 8; f++) m_cfg[f] = '0;
    m_en = '0; m_mode = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state of the outputs
    check("R1 outputs", 16'({hit, hit_idx, hit_dir, hit_dfl, hit_csum, rx_irq, wr_err}), 16'd0);
    // R8 nothing enabled: every identifier accepted
    sweep("R8 no active filter");
    // R1 zeroed config: only id 0 hits filter 0
    wr(2'd1, 0, 11'h001);
    sweep("R1 zero config");
    wr(2'd1, 0, 11'h000);

    // R2/R3/R5/R6/R9/R10 list mode with duplicates and a disabled filter
    wr(2'd0, 0, {1'b1, 1'b0, 3'd3, 6'h10});
    wr(2'd0, 1, {1'b0, 1'b1, 3'd7, 6'h21});
    wr(2'd0, 2, {1'b0, 1'b0, 3'd5, 6'h10});
    wr(2'd0, 3, {1'b1, 1'b0, 3'd2, 6'h3f});
    wr(2'd0, 4, {1'b0, 1'b1, 3'd1, 6'h00});
    wr(2'd0, 5, {1'b1, 1'b1, 3'd6, 6'h2a});
    wr(2'd0, 6, {1'b0, 1'b0, 3'd4, 6'h15});
    wr(2'd0, 7, {1'b1, 1'b0, 3'd0, 6'h21});
    wr(2'd3, 0, 11'h7ff);   // R2: target 3 changes nothing
    wr(2'd1, 0, 11'h0bf);
    sweep("R3/R6/R9 list mode");

    // R11 locked writes rejected, open one accepted
    wr(2'd0, 2, {1'b0, 1'b0, 3'd1, 6'h33});
    wr(2'd1, 0, 11'h000);
    // R4 mask mode on pairs 0 and 2
    wr(2'd0, 1, {1'b0, 1'b1, 3'd7, 6'h30});
    wr(2'd0, 5, {1'b0, 1'b1, 3'd7, 6'h03});
    wr(2'd2, 0, 11'h005);
    wr(2'd1, 0, 11'hff);
    sweep("R4/R5 mask mode");

    // R4 odd enable alone in mask mode: no active filter
    wr(2'd1, 0, 11'h002);
    sweep("R4 odd enable ignored");

    // R11 odd mask locked by its even partner
    wr(2'd1, 0, 11'h001);
    wr(2'd0, 1, {1'b0, 1'b0, 3'd0, 6'h3f});
    wr(2'd0, 3, {1'b0, 1'b0, 3'd6, 6'h01});
    sweep("R11 lock via partner");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule